// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a parallel RGB panel: active-low horizontal and vertical sync, a data-enable strobe, and the column and row of the current active pixel. A host sets every interval through a single-cycle write port. Horizontal intervals are counted in pixel ticks and vertical intervals in lines. Each interval register stores its length minus one, so a stored zero means one unit. A programmable divider turns the system clock into a pixel tick. All raster state advances only on that tick.

Within a line the phases run sync, back porch, active, front porch. Within a frame the lines follow the same order. A line-match pulse marks the start of a chosen active line. A sticky frame interrupt is raised each time the raster wraps back into vertical sync. The host clears it by writing a one to the status register. While the run bit is low, the outputs sit idle and the counters are held at the start of the frame.

Top module: `vtg_top`

## Requirements
- R1: After reset, `hsync_n_o` and `vsync_n_o` are high, and `de_o`, `pix_tick_o`, `line_match_o` and `irq_o` are low. `x_o` and `y_o` are zero.
- R2: Address 10, bits [7:0], holds the tick ratio minus one, and higher data bits are ignored, so the largest ratio is 256. While running, `pix_tick_o` is high for one cycle in every ratio cycles. The first tick comes in cycle ratio-1 after the cycle that set the run bit.
- R3: Addresses 1, 2, 3 and 4 hold the horizontal sync, back porch, active and front porch lengths minus one. Each line is these four intervals in that order, measured in ticks, and `hsync_n_o` is low during the sync interval.
- R4: Addresses 5, 6, 7 and 8 hold the vertical sync, back porch, active and front porch lengths minus one, measured in lines. Each frame runs these four intervals in that order, and `vsync_n_o` is low during the vertical sync interval.
- R5: `de_o` is high exactly when both the horizontal and vertical positions are in their active intervals. At those times `x_o` and `y_o` give the pixel column and row counted from zero within the active area. At all other times both are zero.
- R6: Address 9 holds a line threshold. `line_match_o` pulses for the one tick cycle that starts active line number threshold, at horizontal position zero of that line.
- R7: Control register address 0, bit 1, is the interrupt enable and bit 2 is the frame-interrupt enable. When both are set, the tick that wraps the last front-porch line back into vertical sync sets the pending bit, which drives `irq_o` from the next cycle on. If either enable is clear, the pending bit is not set.
- R8: Writing address 11 with bit 0 set clears the pending bit. Writing it with bit 0 clear leaves the bit unchanged. A frame event in the same cycle as a clear takes priority over the clear.
- R9: Control bit 0 is the run bit. While it is clear, no ticks occur, sync outputs stay high, `de_o` stays low, and the raster returns to line 0, pixel 0, in the sync interval. Setting it again starts a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (4) | Register address |
| wr_data_i | input | DW (32) | Register write data |
| pix_tick_o | output | 1 | Pixel-rate enable |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable |
| x_o | output | CW (12) | Active column |
| y_o | output | CW (12) | Active row |
| line_match_o | output | 1 | Threshold line start pulse |
| irq_o | output | 1 | Pending frame interrupt |

## Verification
The assertions assume that interval and divider registers are rewritten only while the run bit is low. Under that assumption, the outputs hold steady between ticks. They also assume that a status clear lands on a cycle without a tick, so that a clear is always followed by a low `irq_o`. The bench follows both rules. Each configuration is loaded with the block stopped, the block then runs for several whole frames, and it is stopped again before the status register is written.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_H0     = 1;
    localparam int ADDR_V0     = 5;
    localparam int ADDR_THR    = 9;
    localparam int ADDR_DIV    = 10;
    localparam int ADDR_STATUS = 11;
    localparam int NUM_PHASES  = 4;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DW   = 32,
    parameter int CW   = 12,
    parameter int DIVW = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [AW-1:0]                     wr_addr_i,
    input  logic [DW-1:0]                     wr_data_i,
    input  logic                              frame_evt_i,
    output logic                              run_o,
    output logic [NUM_PHASES-1:0][CW-1:0]     h_len_o,
    output logic [NUM_PHASES-1:0][CW-1:0]     v_len_o,
    output logic [CW-1:0]                     thr_o,
    output logic [DIVW-1:0]                   div_o,
    output logic                              irq_o
);
    typedef struct packed {
        logic                          run;
        logic                          irq_en;
        logic                          frm_en;
        logic [NUM_PHASES-1:0][CW-1:0] h_len;
        logic [NUM_PHASES-1:0][CW-1:0] v_len;
        logic [CW-1:0]                 thr;
        logic [DIVW-1:0]               div;
        logic                          pend;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            if (wr_addr_i == AW'(ADDR_CTRL)) begin
                regs_d.run    = wr_data_i[0];
                regs_d.irq_en = wr_data_i[1];
                regs_d.frm_en = wr_data_i[2];
            end
            for (int i = 0; i < NUM_PHASES; i++) begin
                if (wr_addr_i == AW'(ADDR_H0 + i)) regs_d.h_len[i] = wr_data_i[CW-1:0];
                if (wr_addr_i == AW'(ADDR_V0 + i)) regs_d.v_len[i] = wr_data_i[CW-1:0];
            end
            if (wr_addr_i == AW'(ADDR_THR)) regs_d.thr = wr_data_i[CW-1:0];
            if (wr_addr_i == AW'(ADDR_DIV)) regs_d.div = wr_data_i[DIVW-1:0];
            if (wr_addr_i == AW'(ADDR_STATUS) && wr_data_i[0]) regs_d.pend = 1'b0;
        end
        if (frame_evt_i && regs_q.irq_en && regs_q.frm_en) regs_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign run_o   = regs_q.run;
    assign h_len_o = regs_q.h_len;
    assign v_len_o = regs_q.v_len;
    assign thr_o   = regs_q.thr;
    assign div_o   = regs_q.div;
    assign irq_o   = regs_q.pend;
endmodule

// File: rtl/vtg_pixdiv.sv
module vtg_pixdiv #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic tick;

    always_comb begin
        tick  = run_i && (div_q.cnt >= div_i);
        div_d = div_q;
        if (!run_i || tick) div_d.cnt = '0;
        else                div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick_o = tick;
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_i,
    input  logic                          step_i,
    input  logic [NUM_PHASES-1:0][CW-1:0] len_i,
    output phase_e                        phase_o,
    output logic [CW-1:0]                 cnt_o,
    output logic                          wrap_o
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
    } axis_t;

    axis_t axis_d, axis_q;
    logic  last;

    always_comb begin
        last   = axis_q.cnt >= len_i[axis_q.phase];
        axis_d = axis_q;
        if (!run_i) begin
            axis_d.phase = PH_SYNC;
            axis_d.cnt   = '0;
        end else if (step_i) begin
            if (last) begin
                axis_d.cnt   = '0;
                axis_d.phase = phase_e'(axis_q.phase + 2'd1);
            end else begin
                axis_d.cnt = axis_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) axis_q <= '{phase: PH_SYNC, cnt: '0};
        else        axis_q <= axis_d;
    end

    assign phase_o = axis_q.phase;
    assign cnt_o   = axis_q.cnt;
    assign wrap_o  = run_i && step_i && last && (axis_q.phase == PH_FRONT);
endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DW   = 32,
    parameter int CW   = 12,
    parameter int DIVW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          pix_tick_o,
    output logic          hsync_n_o,
    output logic          vsync_n_o,
    output logic          de_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          line_match_o,
    output logic          irq_o
);
    logic                          run, tick, h_wrap, v_wrap;
    logic [NUM_PHASES-1:0][CW-1:0] h_len, v_len;
    logic [CW-1:0]                 thr, h_cnt, v_cnt;
    logic [DIVW-1:0]               div;
    phase_e                        h_ph, v_ph;
    logic                          de;

    vtg_regs #(.AW(AW), .DW(DW), .CW(CW), .DIVW(DIVW)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .frame_evt_i(v_wrap),
        .run_o(run), .h_len_o(h_len), .v_len_o(v_len),
        .thr_o(thr), .div_o(div), .irq_o(irq_o)
    );

    vtg_pixdiv #(.DIVW(DIVW)) i_div (
        .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div), .tick_o(tick)
    );

    vtg_axis #(.CW(CW)) i_h (
        .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(tick), .len_i(h_len),
        .phase_o(h_ph), .cnt_o(h_cnt), .wrap_o(h_wrap)
    );

    vtg_axis #(.CW(CW)) i_v (
        .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(h_wrap), .len_i(v_len),
        .phase_o(v_ph), .cnt_o(v_cnt), .wrap_o(v_wrap)
    );

    always_comb begin
        de           = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);
        de_o         = de;
        hsync_n_o    = !(run && (h_ph == PH_SYNC));
        vsync_n_o    = !(run && (v_ph == PH_SYNC));
        x_o          = de ? h_cnt : '0;
        y_o          = de ? v_cnt : '0;
        pix_tick_o   = tick;
        line_match_o = tick && (h_ph == PH_SYNC) && (h_cnt == '0)
                       && (v_ph == PH_ACT) && (v_cnt == thr);
    end
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [DW-1:0] wr_data_i,
    input logic          pix_tick_o,
    input logic          hsync_n_o,
    input logic          vsync_n_o,
    input logic          de_o,
    input logic [CW-1:0] x_o,
    input logic [CW-1:0] y_o,
    input logic          line_match_o,
    input logic          irq_o
);
    logic clr;
    assign clr = wr_en_i && (wr_addr_i == AW'(ADDR_STATUS)) && wr_data_i[0];

    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_n_o && vsync_n_o)); // R5
    AST_COORD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> (x_o == '0 && y_o == '0)); // R5
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_tick_o && !wr_en_i) |=> ($stable(hsync_n_o) && $stable(vsync_n_o)
                                        && $stable(de_o) && $stable(x_o))); // R3
    AST_VSYNC_FALL_IN_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n_o) |-> !hsync_n_o); // R4
    AST_MATCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        line_match_o |-> pix_tick_o); // R6
    AST_IRQ_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pix_tick_o)); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr) |=> irq_o); // R8
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !pix_tick_o) |=> !irq_o); // R8
endmodule

bind vtg_top vtg_checker #(.AW(AW), .DW(DW), .CW(CW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pix_tick_o(pix_tick_o), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
    .de_o(de_o), .x_o(x_o), .y_o(y_o),
    .line_match_o(line_match_o), .irq_o(irq_o)
);

// File: tb/test_vtg_top.sv
`timescale 1ns/1ps
module test_vtg_top;
    localparam int AW = 4, DW = 32, CW = 12, DIVW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          tick, hs_n, vs_n, de, lm, irq;
    logic [CW-1:0] x, y;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vtg_top #(.AW(AW), .DW(DW), .CW(CW), .DIVW(DIVW)) i_vtg_top (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pix_tick_o(tick), .hsync_n_o(hs_n), .vsync_n_o(vs_n), .de_o(de),
        .x_o(x), .y_o(y), .line_match_o(lm), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = DW'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check_idle(input string req);
        chk({req, " hsync_n idle"}, int'(hs_n), 1);
        chk({req, " vsync_n idle"}, int'(vs_n), 1);
        chk({req, " de idle"}, int'(de), 0);
        chk({req, " tick idle"}, int'(tick), 0);
        chk({req, " match idle"}, int'(lm), 0);
    endtask

    // Load a configuration while stopped, run for ncyc cycles, compare every cycle.
    task automatic run_cfg(input int hl[4], input int vl[4], input int thr,
                           input int divw, input int ctrl, input int ncyc);
        int H, V, HV, d, hb, ha, vb, va;
        H = 0; V = 0;
        for (int i = 0; i < 4; i++) begin
            wr(1 + i, hl[i]);
            wr(5 + i, vl[i]);
            H += hl[i] + 1;
            V += vl[i] + 1;
        end
        wr(9, thr);
        wr(10, divw);
        wr(11, 1);
        HV = H * V;
        d  = divw & 255;
        hb = hl[0] + 1 + hl[1] + 1;
        ha = hb + hl[2] + 1;
        vb = vl[0] + 1 + vl[1] + 1;
        va = vb + vl[2] + 1;
        wr(0, ctrl);
        for (int k = 0; k < ncyc; k++) begin
            int idx, pos, row, col, etick, eact;
            idx   = k / (d + 1);
            pos   = idx % HV;
            row   = pos / H;
            col   = pos % H;
            etick = ((k % (d + 1)) == d) ? 1 : 0;
            eact  = (col >= hb && col < ha && row >= vb && row < va) ? 1 : 0;
            chk("R2 pixel tick", int'(tick), etick);
            chk("R3 hsync_n", int'(hs_n), (col <= hl[0]) ? 0 : 1);
            chk("R4 vsync_n", int'(vs_n), (row <= vl[0]) ? 0 : 1);
            chk("R5 de", int'(de), eact);
            chk("R5 x", int'(x), eact != 0 ? col - hb : 0);
            chk("R5 y", int'(y), eact != 0 ? row - vb : 0);
            chk("R6 line match", int'(lm),
                (etick != 0 && col == 0 && row == vb + thr) ? 1 : 0);
            chk("R7 irq", int'(irq),
                (((ctrl >> 1) & 3) == 3 && idx >= HV) ? 1 : 0);
            @(negedge clk);
        end
        wr(0, 0);
        check_idle("R9 stopped");
        repeat (5) @(negedge clk);
        check_idle("R9 stays stopped");
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 x reset", int'(x), 0);
        chk("R1 y reset", int'(y), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after release");

        // minimal raster, every interval one unit, full rate, interrupts on
        run_cfg('{0, 0, 0, 0}, '{0, 0, 0, 0}, 0, 0, 7, 48);
        chk("R8 pending kept while stopped", int'(irq), 1);
        wr(11, 0);
        chk("R8 write zero ignored", int'(irq), 1);
        wr(11, 1);
        chk("R8 write one clears", int'(irq), 0);

        // uneven intervals, ratio 3, threshold on second active line
        run_cfg('{0, 1, 3, 1}, '{0, 1, 2, 0}, 1, 2, 7, 3 * 63 * 3);
        wr(11, 1);
        chk("R8 clear after second run", int'(irq), 0);

        // frame interrupt enable off: pending must stay low
        run_cfg('{1, 0, 2, 2}, '{1, 2, 1, 1}, 0, 0, 3, 2 * 90);
        // interrupt enable off, frame enable on
        run_cfg('{0, 0, 1, 0}, '{0, 0, 1, 0}, 1, 1, 5, 2 * 2 * 25);

        // divider cap: upper data bits ignored, ratio 256
        run_cfg('{0, 0, 0, 0}, '{0, 0, 0, 0}, 0, 32'h1FF, 7, 600);

        // restart after stop begins a fresh frame
        run_cfg('{2, 1, 4, 0}, '{0, 0, 3, 1}, 3, 1, 7, 2 * 2 * 96);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule